// File: doc/BRIEF.md
# Vectored Programmable-Priority Interrupt Controller

This block collects interrupt events for a small 8-bit processor core. There are six sources. Four of them are external pins. Each pin passes through a two-stage synchronizer and an edge detector. Pins 0 and 2 have a selectable edge type. Pins 1 and 3 react only to a falling edge. Three internal event pulses also feed the block: a serial-port pulse shares source 3, and two timer pulses drive sources 4 and 5. Every detected event sets a latched request flag, and the flag holds until software clears it or the source is granted.

A mask register gates each source, and a global enable bit gates all of them together. A rotating priority resolver picks one winner from the requests that are both pending and unmasked. Software chooses which source ranks highest. When the core acknowledges a request, the block does three things in the same clock:
- it clears the winner's request flag,
- it clears the global enable,
- it presents the program-memory address of the winner's two-byte service vector.

Software can also leave the mask bits off and poll the request register instead.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the following are all zero: the request register (address 0), the mask register (address 1), the priority register (address 2), `irq_o`, `vec_valid_o` and `vec_addr_o`. Address 3 always reads zero.
- R2: A detected pin edge sets its request flag three rising clock edges after the pin changes, not sooner. The flag then stays set with no further stimulus.
- R3: Request-register bits 7:6 choose the edge type for sources 0 and 2 together. The codes are: 00 falling edge, 01 rising edge, 10 both edges, 11 falling edge.
- R4: Sources 1 and 3 set their flags on a falling pin edge only, never on a rising edge.
- R5: A one-cycle pulse on `uart_evt_i` sets request bit 3. A pulse on `tmr0_evt_i` sets bit 4, and a pulse on `tmr1_evt_i` sets bit 5. In each case the bit is set after the next rising clock edge.
- R6: `irq_o` is high exactly when mask bit 7 (global enable) is set and request[5:0] AND mask[5:0] is non-zero.
- R7: A request whose mask bit is clear is still latched and reads back in request[5:0], and it does not raise `irq_o`.
- R8: Take the priority register bits 2:0, modulo 6, as the top-priority source. Rank then falls in ascending index order, wrapping from 5 to 0. The winner is the highest-ranked source that is both pending and unmasked.
- R9: If `ack_i` is high at a rising edge while `irq_o` is high, then after that edge three things hold for one cycle: `vec_addr_o` equals twice the winner's index, `vec_valid_o` is high, and both the winner's request bit and mask bit 7 are clear.
- R10: If `ack_i` is high while `irq_o` is low, there is no effect: `vec_valid_o` stays low, `vec_addr_o` keeps its value, and the registers are unchanged.
- R11: A write to address 0 loads bits 7:6 and bits 5:0 from the written data. Writing a 1 to a flag raises a software request, and writing a 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 4 | External interrupt pins for sources 0..3 |
| uart_evt_i | input | 1 | Serial-port event pulse (source 3) |
| tmr0_evt_i | input | 1 | First timer event pulse (source 4) |
| tmr1_evt_i | input | 1 | Second timer event pulse (source 5) |
| reg_addr_i | input | 2 | Register select: 0 request, 1 mask, 2 priority |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |
| ack_i | input | 1 | Core acknowledge pulse |
| irq_o | output | 1 | Interrupt request to the core |
| vec_addr_o | output | 8 | Vector address, twice the granted index |
| vec_valid_o | output | 1 | One-cycle strobe for a new vector address |

## Verification
The hardest situation to reach is resolving among several pending sources while the top-priority pointer sits at each of its eight encodings, including the two that wrap modulo 6. Edge timing is too slow and too coarse to set this up from the pins. Instead, the bench preloads the request register with every non-zero six-bit pattern through the software write path. It then programs each priority value, acknowledges once, and compares the vector address and the remaining flags against a winner computed by rotation. Edge-type coverage is reached separately, by sweeping all four edge codes with rising and falling pin transitions on both configurable pins.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC = 6;
    localparam int DW   = 8;
    localparam int PW   = 3;
    localparam int IW   = $clog2(NSRC);

    localparam logic [1:0] ADDR_REQ  = 2'd0;
    localparam logic [1:0] ADDR_MASK = 2'd1;
    localparam logic [1:0] ADDR_PRIO = 2'd2;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_RSVD = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic [DW-1:0] req;
        logic [DW-1:0] mask;
        logic [PW-1:0] prio;
        logic [DW-1:0] vec;
        logic          valid;
    } ctrl_state_t;
endpackage

// File: rtl/irq_edge_unit.sv
module irq_edge_unit
    import irq_pkg::*;
#(
    parameter bit CONFIGURABLE = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  edge_mode_e mode_i,
    output logic       pulse_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t st_d, st_q;
    logic  rise, fall;

    always_comb begin
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.s2 & ~st_q.prev;
    assign fall = ~st_q.s2 & st_q.prev;

    generate
        if (CONFIGURABLE) begin : g_cfg
            always_comb begin
                unique case (mode_i)
                    EDGE_RISE: pulse_o = rise;
                    EDGE_BOTH: pulse_o = rise | fall;
                    default:   pulse_o = fall;
                endcase
            end
        end else begin : g_fall
            assign pulse_o = fall;
            AST_FIXED_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(st_q.s2) |-> !pulse_o) else $error("rising edge fired"); // R4
        end
    endgenerate
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend_i,
    input  logic [PW-1:0]   top_i,
    output logic [IW-1:0]   win_o,
    output logic            any_o
);
    int unsigned top_m;

    always_comb begin
        top_m = (int'(top_i) >= NSRC) ? int'(top_i) - NSRC : int'(top_i);
        win_o = '0;
        any_o = 1'b0;
        for (int k = 0; k < NSRC; k++) begin
            int unsigned idx;
            idx = top_m + k;
            if (idx >= NSRC) idx = idx - NSRC;
            if (!any_o && pend_i[idx]) begin
                any_o = 1'b1;
                win_o = IW'(idx);
            end
        end
    end

    AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> pend_i[win_o]) else $error("winner not pending"); // R8
    AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i[top_m] && top_m < NSRC) |-> (int'(win_o) == int'(top_m))) else $error("top lost"); // R8
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    pin_i,
    input  logic          uart_evt_i,
    input  logic          tmr0_evt_i,
    input  logic          tmr1_evt_i,
    input  logic [1:0]    reg_addr_i,
    input  logic          reg_wr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    input  logic          ack_i,
    output logic          irq_o,
    output logic [DW-1:0] vec_addr_o,
    output logic          vec_valid_o
);
    localparam int NPIN = 4;
    localparam int GIE  = DW - 1;

    ctrl_state_t     st_d, st_q;
    logic [NPIN-1:0] pin_pulse;
    logic [NSRC-1:0] evt, pend;
    logic [IW-1:0]   win;
    logic            any;
    logic            grant;
    edge_mode_e      mode;

    assign mode = edge_mode_e'(st_q.req[DW-1:DW-2]);

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        irq_edge_unit #(.CONFIGURABLE(i == 0 || i == 2)) u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pin_i[i]),
            .mode_i  (mode),
            .pulse_o (pin_pulse[i])
        );
    end

    assign evt = {tmr1_evt_i, tmr0_evt_i, pin_pulse[3] | uart_evt_i, pin_pulse[2:0]};
    assign pend = st_q.req[NSRC-1:0] & st_q.mask[NSRC-1:0];

    irq_prio_pick u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .top_i  (st_q.prio),
        .win_o  (win),
        .any_o  (any)
    );

    assign irq_o = st_q.mask[GIE] & any;
    assign grant = ack_i & irq_o;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (reg_wr_i) begin
            unique case (reg_addr_i)
                ADDR_REQ:  st_d.req  = reg_wdata_i;
                ADDR_MASK: st_d.mask = {reg_wdata_i[GIE], 1'b0, reg_wdata_i[NSRC-1:0]};
                ADDR_PRIO: st_d.prio = reg_wdata_i[PW-1:0];
                default: ;
            endcase
        end
        if (grant) begin
            st_d.req[win]   = 1'b0;
            st_d.mask[GIE]  = 1'b0;
            st_d.vec        = DW'({win, 1'b0});
            st_d.valid      = 1'b1;
        end
        st_d.req[NSRC-1:0] = st_d.req[NSRC-1:0] | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (reg_addr_i)
            ADDR_REQ:  reg_rdata_o = st_q.req;
            ADDR_MASK: reg_rdata_o = st_q.mask;
            ADDR_PRIO: reg_rdata_o = DW'(st_q.prio);
            default:   reg_rdata_o = '0;
        endcase
    end

    assign vec_addr_o  = st_q.vec;
    assign vec_valid_o = st_q.valid;

    AST_GRANT_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !st_q.mask[GIE] && !irq_o) else $error("enable kept"); // R9
    AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> (!vec_addr_o[0] && vec_addr_o <= DW'(2*(NSRC-1)))) else $error("bad vector"); // R9
    AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_o) |=> !vec_valid_o && $stable(vec_addr_o)) else $error("idle ack acted"); // R10
    AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        tmr1_evt_i |=> st_q.req[NSRC-1]) else $error("timer event lost"); // R5
endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin = '0;
    logic       uart = 1'b0, t0 = 1'b0, t1 = 1'b0;
    logic [1:0] addr = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ack = 1'b0;
    logic       irq;
    logic [7:0] vec;
    logic       vvalid;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    irq_vec_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin),
        .uart_evt_i(uart), .tmr0_evt_i(t0), .tmr1_evt_i(t1),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .ack_i(ack), .irq_o(irq), .vec_addr_o(vec), .vec_valid_o(vvalid)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic do_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    function automatic int exp_win(int pat, int top);
        int t = top % 6;
        for (int k = 0; k < 6; k++) begin
            int idx = (t + k) % 6;
            if (pat[idx]) return idx;
        end
        return -1;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd_reg(2'd0, d); chk("R1 req", d, 0);
        rd_reg(2'd1, d); chk("R1 mask", d, 0);
        rd_reg(2'd2, d); chk("R1 prio", d, 0);
        chk("R1 irq", irq, 0); chk("R1 valid", vvalid, 0); chk("R1 vec", vec, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_reg(2'd3, d); chk("R1 addr3", d, 0);

        // R4: sources 1 and 3 fall only; R2 latency
        for (int s = 1; s < 4; s += 2) begin
            wr_reg(2'd0, 8'h00);
            pin[s] = 1'b1;
            repeat (3) @(negedge clk);
            rd_reg(2'd0, d); chk("R4 no rise", d[s], 0);
            pin[s] = 1'b0;
            repeat (2) @(negedge clk);
            rd_reg(2'd0, d); chk("R2 not early", d[s], 0);
            @(negedge clk);
            rd_reg(2'd0, d); chk("R4 fall", d[s], 1);
            repeat (4) @(negedge clk);
            rd_reg(2'd0, d); chk("R2 held", d[s], 1);
        end

        // R3 edge-type sweep on sources 0 and 2
        for (int s = 0; s < 3; s += 2) begin
            for (int m = 0; m < 4; m++) begin
                wr_reg(2'd0, 8'(m << 6));
                pin[s] = 1'b1;
                repeat (3) @(negedge clk);
                rd_reg(2'd0, d); chk("R3 rise", d[s], (m == 1 || m == 2) ? 1 : 0);
                chk("R3 mode kept", d[7:6], m);
                wr_reg(2'd0, 8'(m << 6));
                pin[s] = 1'b0;
                repeat (3) @(negedge clk);
                rd_reg(2'd0, d); chk("R3 fall", d[s], (m == 1) ? 0 : 1);
            end
        end

        // R5 internal pulses
        wr_reg(2'd0, 8'h00);
        @(negedge clk); uart = 1'b1; @(negedge clk); uart = 1'b0;
        rd_reg(2'd0, d); chk("R5 uart", d[5:0], 6'h08);
        @(negedge clk); t0 = 1'b1; @(negedge clk); t0 = 1'b0;
        rd_reg(2'd0, d); chk("R5 tmr0", d[5:0], 6'h18);
        @(negedge clk); t1 = 1'b1; @(negedge clk); t1 = 1'b0;
        rd_reg(2'd0, d); chk("R5 tmr1", d[5:0], 6'h38);

        // R7 polling with masks off, R6 gating
        wr_reg(2'd1, 8'h80);
        #1; chk("R7 masked irq", irq, 0);
        rd_reg(2'd0, d); chk("R7 poll", d[5:0], 6'h38);
        wr_reg(2'd1, 8'h10);
        #1; chk("R6 gie off", irq, 0);
        wr_reg(2'd1, 8'h90);
        #1; chk("R6 gie on", irq, 1);

        // R10 idle ack
        wr_reg(2'd1, 8'h81);
        do_ack();
        chk("R10 valid", vvalid, 0); chk("R10 vec", vec, 0);
        rd_reg(2'd0, d); chk("R10 req", d[5:0], 6'h38);
        rd_reg(2'd1, d); chk("R10 mask", d, 8'h81);

        // R11 software write clears/sets
        wr_reg(2'd0, 8'h05);
        rd_reg(2'd0, d); chk("R11 write", d, 8'h05);

        // R8/R9 exhaustive priority sweep
        for (int top = 0; top < 8; top++) begin
            for (int pat = 1; pat < 64; pat++) begin
                int w;
                w = exp_win(pat, top);
                wr_reg(2'd0, 8'(pat));
                wr_reg(2'd1, 8'hBF);
                wr_reg(2'd2, 8'(top));
                #1; chk("R6 irq", irq, 1);
                do_ack();
                chk("R9 valid", vvalid, 1);
                chk("R8 vec", vec, 2 * w);
                rd_reg(2'd0, d); chk("R9 req clr", d[5:0], pat & ~(1 << w));
                rd_reg(2'd1, d); chk("R9 gie clr", d, 8'h3F);
                rd_reg(2'd2, d); chk("R8 prio rd", d, top);
                @(negedge clk);
                chk("R9 pulse", vvalid, 0);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule